// File: doc/BRIEF.md
# Free-Hole Allocator with Selectable Fit Policy

This block keeps a table of free memory regions ("holes"), each with a base address and a length. It serves two kinds of request: an allocation of `n` units, which carves the grant from one hole, and a release, which files a region back into the table as a new hole. Neighbouring holes are never merged.

The hole is picked by a policy chosen with each allocation request. First-fit takes the lowest-indexed hole that is large enough. Best-fit takes the smallest hole that is large enough. Worst-fit takes the largest hole. One scan engine reads one table entry per clock and runs all three policies. Each policy has its own comparison and its own stopping rule. A request that no single hole can hold fails, even when the free space adds up to enough.

Requests enter on a valid/ready channel, and results leave on a valid/ready channel. The block serves one request at a time. `req_ready` is high only while the block is idle, so a request waits, held by its source, until the previous response has been accepted. A response stays on the outputs, unchanged, until `rsp_ready` takes it. Nothing is dropped under back-pressure.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds no hole, `req_ready` is 1 and `rsp_valid` is 0, so an allocation made straight after reset fails.
- R2: Only one request is in flight. `req_ready` falls on the cycle after acceptance and stays 0 until the response has been taken. `rsp_valid` and `req_ready` are never high together. While `rsp_ready` is 0, `rsp_valid`, `rsp_ok` and `rsp_addr` hold their values.
- R3: An allocation is `req_op`=0. With `req_policy` 0 (or 3, which acts the same), the scan grants the lowest-index valid hole whose length is at least `req_size`. It stops there, and the response appears k+3 cycles after acceptance, where k is that hole's index.
- R4: With `req_policy` 1, the scan grants the smallest valid hole whose length is at least `req_size`, and the lowest index wins a tie. Every one of the N entries is visited, so the response appears N+2 cycles after acceptance.
- R5: With `req_policy` 2, the scan grants the largest valid hole, provided it holds `req_size`, and the lowest index wins a tie. It also visits all N entries and responds after N+2 cycles.
- R6: A grant returns `rsp_ok`=1 and the chosen hole's old base on `rsp_addr`. The hole then starts `req_size` higher and is `req_size` shorter.
- R7: A hole whose length falls to zero becomes invalid, and a later release may reuse its slot.
- R8: When no single valid hole can hold the request, even with enough total free space, the response is `rsp_ok`=0 and `rsp_addr`=0.
- R9: A release is `req_op`=1. It writes base `req_addr` and length `req_size` into the lowest-index invalid entry. The response is `rsp_ok`=1 with `rsp_addr`=`req_addr`, two cycles after acceptance.
- R10: A release while all N entries are valid fails with `rsp_ok`=0 and `rsp_addr`=0, and it leaves the table unchanged.
- R11: A request with `req_size`=0, whether allocation or release, fails one cycle after acceptance and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 allocate, 1 release |
| req_policy | input | 2 | 0 first-fit, 1 best-fit, 2 worst-fit, 3 first-fit |
| req_size | input | AW | Allocation size, or length of the released region |
| req_addr | input | AW | Base of the released region (ignored for allocations) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ok | output | 1 | 1 when the request succeeded |
| rsp_addr | output | AW | Granted base, echoed release base, or 0 on failure |

## Verification
The bench first builds a table of holes of different sizes. It then makes requests chosen so that the three policies would pick different holes from the same table, so a wrong comparison or a wrong stopping rule shows up as a wrong address. Some patterns contain equal-length holes, which expose a tie broken toward the wrong index. Requests that fit only in the sum of several holes check that fragmentation is reported as a failure. Response latency is measured on every request, and this separates the early-stopping first-fit scan from the full scans of the other two policies. The remaining requests cover exact-fit removal, slot reuse, a full table and zero-size requests.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;

  typedef enum logic [1:0] {
    FIT_FIRST     = 2'd0,
    FIT_BEST      = 2'd1,
    FIT_WORST     = 2'd2,
    FIT_FIRST_ALT = 2'd3
  } fit_e;

  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FREE,
    ST_RESP
  } state_e;

endpackage

// File: rtl/hole_table.sv
module hole_table #(
  parameter int N  = 16,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] scan_idx,
  output logic          scan_valid,
  output logic [AW-1:0] scan_len,
  input  logic [IW-1:0] pick_idx,
  output logic [AW-1:0] pick_base,
  input  logic          shr_en,
  input  logic [IW-1:0] shr_idx,
  input  logic [AW-1:0] shr_size,
  input  logic          ins_en,
  input  logic [IW-1:0] ins_idx,
  input  logic [AW-1:0] ins_base,
  input  logic [AW-1:0] ins_len,
  output logic [N-1:0]  occ
);

  logic [AW-1:0] base_q [N];
  logic [AW-1:0] len_q  [N];
  logic [N-1:0]  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (shr_en && shr_idx == IW'(i)) begin
          base_q[i] <= base_q[i] + shr_size;
          len_q[i]  <= len_q[i] - shr_size;
          vld_q[i]  <= (len_q[i] != shr_size);
        end else if (ins_en && ins_idx == IW'(i)) begin
          base_q[i] <= ins_base;
          len_q[i]  <= ins_len;
          vld_q[i]  <= 1'b1;
        end
      end
    end
  end

  assign scan_valid = vld_q[scan_idx];
  assign scan_len   = len_q[scan_idx];
  assign pick_base  = base_q[pick_idx];
  assign occ        = vld_q;

endmodule

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  occ,
  output logic          has_slot,
  output logic [IW-1:0] slot_idx
);

  always_comb begin
    has_slot = 1'b0;
    slot_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        has_slot = 1'b1;
        slot_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/fit_scan.sv
module fit_scan
  import hole_alloc_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fit_e          policy,
  input  logic [AW-1:0] need,
  output logic [IW-1:0] idx,
  input  logic          ent_valid,
  input  logic [AW-1:0] ent_len,
  output logic          done,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);

  logic          busy;
  logic [AW-1:0] hit_len;
  logic          fits, better, take, last, stop, is_first;

  always_comb begin
    is_first = (policy != FIT_BEST) && (policy != FIT_WORST);
    fits     = ent_valid && (ent_len >= need);
    unique case (policy)
      FIT_BEST:  better = !hit || (ent_len < hit_len);
      FIT_WORST: better = !hit || (ent_len > hit_len);
      default:   better = !hit;
    endcase
    take = busy && fits && better;
    last = (idx == IW'(N - 1));
    stop = busy && (last || (is_first && fits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      hit     <= 1'b0;
      hit_idx <= '0;
      hit_len <= '0;
      done    <= 1'b0;
    end else begin
      done <= stop;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        hit  <= 1'b0;
      end else if (busy) begin
        if (take) begin
          hit     <= 1'b1;
          hit_idx <= idx;
          hit_len <= ent_len;
        end
        if (stop) busy <= 1'b0;
        else      idx  <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
  import hole_alloc_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [1:0]    req_policy,
  input  logic [AW-1:0] req_size,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_addr
);

  localparam int IW = $clog2(N);

  state_e        state;
  fit_e          pol_q;
  logic [AW-1:0] size_q, addr_q;
  logic          accept, scan_start;
  logic [IW-1:0] scan_idx, hit_idx, slot_idx;
  logic          scan_valid, scan_done, scan_hit, has_slot;
  logic [AW-1:0] scan_len, pick_base;
  logic [N-1:0]  occ;
  logic          shr_en, ins_en;

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RESP);
  assign accept     = req_valid && req_ready;
  assign scan_start = accept && (op_e'(req_op) == OP_ALLOC) && (req_size != '0);
  assign shr_en     = (state == ST_SCAN) && scan_done && scan_hit;
  assign ins_en     = (state == ST_FREE) && has_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pol_q    <= FIT_FIRST;
      size_q   <= '0;
      addr_q   <= '0;
      rsp_ok   <= 1'b0;
      rsp_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          pol_q  <= fit_e'(req_policy);
          size_q <= req_size;
          addr_q <= req_addr;
          if (req_size == '0) begin
            rsp_ok   <= 1'b0;
            rsp_addr <= '0;
            state    <= ST_RESP;
          end else if (op_e'(req_op) == OP_ALLOC) begin
            state <= ST_SCAN;
          end else begin
            state <= ST_FREE;
          end
        end
        ST_SCAN: if (scan_done) begin
          rsp_ok   <= scan_hit;
          rsp_addr <= scan_hit ? pick_base : '0;
          state    <= ST_RESP;
        end
        ST_FREE: begin
          rsp_ok   <= has_slot;
          rsp_addr <= has_slot ? addr_q : '0;
          state    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  hole_table #(.N(N), .AW(AW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_idx  (scan_idx),
    .scan_valid(scan_valid),
    .scan_len  (scan_len),
    .pick_idx  (hit_idx),
    .pick_base (pick_base),
    .shr_en    (shr_en),
    .shr_idx   (hit_idx),
    .shr_size  (size_q),
    .ins_en    (ins_en),
    .ins_idx   (slot_idx),
    .ins_base  (addr_q),
    .ins_len   (size_q),
    .occ       (occ)
  );

  slot_finder #(.N(N)) u_slot (
    .occ     (occ),
    .has_slot(has_slot),
    .slot_idx(slot_idx)
  );

  fit_scan #(.N(N), .AW(AW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_start),
    .policy   (pol_q),
    .need     (size_q),
    .idx      (scan_idx),
    .ent_valid(scan_valid),
    .ent_len  (scan_len),
    .done     (scan_done),
    .hit      (scan_hit),
    .hit_idx  (hit_idx)
  );

endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int N  = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_op,
  input logic [1:0]    req_policy,
  input logic [AW-1:0] req_size,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_addr
);

  localparam int CW = $clog2(N + 4) + 1;

  logic [CW-1:0] cnt;
  logic          op_q;
  logic [1:0]    pol_q;
  logic          zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      op_q   <= 1'b0;
      pol_q  <= '0;
      zero_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      cnt    <= CW'(1);
      op_q   <= req_op;
      pol_q  <= req_policy;
      zero_q <= (req_size == '0);
    end else if (!req_ready && !rsp_valid) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: one request in flight
  a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_addr));

  // R8, R10: failure carries address zero
  a_r8_fail_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_addr == '0);

  // R4, R5: full scan latency
  a_r4_full_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !op_q && !zero_q && (pol_q == 2'd1 || pol_q == 2'd2)
      |-> cnt == CW'(N + 2));

  // R9: release latency
  a_r9_free_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && op_q && !zero_q |-> cnt == CW'(2));

  // R11: zero-size requests fail at once
  a_r11_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && zero_q |-> cnt == CW'(1) && !rsp_ok);

endmodule

bind hole_alloc hole_alloc_chk #(.N(N), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_policy(req_policy),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ok    (rsp_ok),
  .rsp_addr  (rsp_addr)
);

// File: tb/hole_alloc_bench.sv
module hole_alloc_bench;

  localparam int N  = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [1:0]    req_policy = 2'd0;
  logic [AW-1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_ok;
  logic [AW-1:0] rsp_addr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hole_alloc #(.N(N), .AW(AW)) u_hole_alloc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_policy(req_policy), .req_size(req_size), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ok(rsp_ok), .rsp_addr(rsp_addr)
  );

  typedef struct packed {
    logic        op;
    logic [1:0]  pol;
    logic [15:0] size;
    logic [15:0] addr;
    logic        ok;
    logic [15:0] eaddr;
    logic [7:0]  lat;
    logic [7:0]  req;
  } vec_t;

  // op, policy, size, addr, expected ok, expected addr, latency, requirement
  localparam vec_t VEC [24] = '{
    '{1'b1, 2'd0, 16'h0040, 16'h0100, 1'b1, 16'h0100, 8'd2,  8'd9},  // R9 e0
    '{1'b1, 2'd0, 16'h0010, 16'h0200, 1'b1, 16'h0200, 8'd2,  8'd9},  // R9 e1
    '{1'b1, 2'd0, 16'h0080, 16'h0300, 1'b1, 16'h0300, 8'd2,  8'd9},  // R9 e2
    '{1'b1, 2'd0, 16'h0010, 16'h0400, 1'b1, 16'h0400, 8'd2,  8'd9},  // R9 e3
    '{1'b1, 2'd0, 16'h0020, 16'h0500, 1'b1, 16'h0500, 8'd2,  8'd9},  // R9 e4
    '{1'b0, 2'd0, 16'h0018, 16'h0000, 1'b1, 16'h0100, 8'd3,  8'd3},  // R3 k=0
    '{1'b0, 2'd1, 16'h0010, 16'h0000, 1'b1, 16'h0200, 8'd18, 8'd4},  // R4 tie e1/e3
    '{1'b0, 2'd2, 16'h0008, 16'h0000, 1'b1, 16'h0300, 8'd18, 8'd5},  // R5
    '{1'b0, 2'd1, 16'h001C, 16'h0000, 1'b1, 16'h0500, 8'd18, 8'd4},  // R4
    '{1'b0, 2'd0, 16'h0010, 16'h0000, 1'b1, 16'h0118, 8'd3,  8'd6},  // R6 shrunk base
    '{1'b0, 2'd0, 16'h0030, 16'h0000, 1'b1, 16'h0308, 8'd5,  8'd3},  // R3 k=2
    '{1'b0, 2'd2, 16'h0050, 16'h0000, 1'b0, 16'h0000, 8'd18, 8'd8},  // R8
    '{1'b0, 2'd0, 16'h0050, 16'h0000, 1'b0, 16'h0000, 8'd18, 8'd8},  // R8
    '{1'b0, 2'd1, 16'h0004, 16'h0000, 1'b1, 16'h051C, 8'd18, 8'd6},  // R6
    '{1'b1, 2'd0, 16'h0050, 16'h0600, 1'b1, 16'h0600, 8'd2,  8'd7},  // R7 reuse e1
    '{1'b0, 2'd0, 16'h0050, 16'h0000, 1'b1, 16'h0600, 8'd4,  8'd7},  // R7 k=1
    '{1'b0, 2'd2, 16'h0048, 16'h0000, 1'b1, 16'h0338, 8'd18, 8'd7},  // R7 exact fit
    '{1'b0, 2'd1, 16'h0000, 16'h0000, 1'b0, 16'h0000, 8'd1,  8'd11}, // R11
    '{1'b1, 2'd0, 16'h0000, 16'h0700, 1'b0, 16'h0000, 8'd1,  8'd11}, // R11
    '{1'b0, 2'd2, 16'h0010, 16'h0000, 1'b1, 16'h0128, 8'd18, 8'd5},  // R5
    '{1'b0, 2'd2, 16'h0008, 16'h0000, 1'b1, 16'h0400, 8'd18, 8'd5},  // R5
    '{1'b0, 2'd2, 16'h0008, 16'h0000, 1'b1, 16'h0138, 8'd18, 8'd5},  // R5 tie
    '{1'b0, 2'd1, 16'h0008, 16'h0000, 1'b1, 16'h0408, 8'd18, 8'd4},  // R4
    '{1'b0, 2'd0, 16'h0001, 16'h0000, 1'b0, 16'h0000, 8'd18, 8'd8}   // R8 empty
  };

  task automatic check(input bit cond, input int req, input string what,
                       input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic op, input logic [1:0] pol,
                        input logic [15:0] size, input logic [15:0] addr,
                        input int hold, output logic ok,
                        output logic [15:0] oaddr, output int lat);
    @(negedge clk);
    req_op = op; req_policy = pol; req_size = size; req_addr = addr;
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    ok = rsp_ok;
    oaddr = rsp_addr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      // R2: response held under back-pressure
      check(rsp_valid && !req_ready && rsp_addr == oaddr && rsp_ok == ok, 2,
            "held response", int'(rsp_addr), int'(oaddr));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    logic ok;
    logic [15:0] a;
    int lat;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, 1, "req_ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, 1, "rsp_valid after reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    do_req(1'b0, 2'd1, 16'h0001, 16'h0, 0, ok, a, lat);
    check(ok == 1'b0, 1, "alloc on empty table ok", int'(ok), 0);
    check(lat == 18, 1, "alloc on empty table latency", lat, 18);

    for (int v = 0; v < 24; v++) begin
      do_req(VEC[v].op, VEC[v].pol, VEC[v].size, VEC[v].addr, 0, ok, a, lat);
      check(ok == VEC[v].ok, int'(VEC[v].req), $sformatf("vector %0d ok", v),
            int'(ok), int'(VEC[v].ok));
      check(a == VEC[v].eaddr, int'(VEC[v].req), $sformatf("vector %0d addr", v),
            int'(a), int'(VEC[v].eaddr));
      check(lat == int'(VEC[v].lat), int'(VEC[v].req),
            $sformatf("vector %0d latency", v), lat, int'(VEC[v].lat));
    end

    // R9: fill every slot
    for (int i = 0; i < N; i++) begin
      do_req(1'b1, 2'd0, 16'h0010, 16'(16'h1000 + i * 16'h0100), 0, ok, a, lat);
      check(ok == 1'b1 && a == 16'(16'h1000 + i * 16'h0100), 9, "fill release",
            int'(a), 16'h1000 + i * 16'h0100);
    end
    // R10: overflow on a full table
    do_req(1'b1, 2'd0, 16'h0020, 16'h9000, 0, ok, a, lat);
    check(ok == 1'b0, 10, "overflow ok", int'(ok), 0);
    check(a == 16'h0, 10, "overflow addr", int'(a), 0);
    do_req(1'b0, 2'd2, 16'h0011, 16'h0, 0, ok, a, lat);
    check(ok == 1'b0, 10, "table unchanged after overflow", int'(ok), 0);

    // R3 with policy 3 and R2 back-pressure
    do_req(1'b0, 2'd3, 16'h0001, 16'h0, 5, ok, a, lat);
    check(ok == 1'b1 && a == 16'h1000, 3, "policy 3 first-fit addr", int'(a), 16'h1000);
    check(lat == 3, 3, "policy 3 first-fit latency", lat, 3);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, 2, "idle after handshake",
          int'(req_ready), 1);

    // R4: smallest that fits among many equal holes
    do_req(1'b0, 2'd1, 16'h0010, 16'h0, 0, ok, a, lat);
    check(ok == 1'b1 && a == 16'h1100, 4, "best-fit among equals", int'(a), 16'h1100);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule